// File: doc/BRIEF.md
# Interrupt status and mask unit

This unit gathers single-cycle event pulses from the receive, transmit, remote DMA, statistics and reset logic of a network controller and holds each one in a sticky bit of an 8-bit interrupt status word. A 7-bit mask selects which of the seven event bits may raise the single interrupt line. The interrupt line is a registered level.

The host reads the status word and clears event bits by writing ones to them. It writes the mask in the same way. The top bit of the status word is not a latched event. It is a read-only level that reports whether the controller is stopped or has overrun its receive ring. It has no mask bit and does not drive the interrupt line.

The receive-error event stands for any of these: bad CRC, misaligned frame, receive FIFO overrun, or a frame missed for lack of ring space. The transmit-error event stands for excessive collisions or a transmit FIFO underrun. The counter event fires when the top bit of any statistics counter becomes 1.

Top module: `isr_unit`

## Requirements
- R1: After reset, status_o is 8'h80 (the controller starts out stopped), mask_o is 0 and irq_o is 0.
- R2: A pulse on event_i[i] sets status_o[i] at the next clock edge, and the bit stays set until the host clears it. The bits are: 0 receive ok, 1 transmit ok, 2 receive error, 3 transmit error, 4 ring overwrite, 5 counter overflow, 6 remote DMA done.
- R3: When event_i[i] and a host clear of bit i arrive in the same cycle, status_o[i] is 1 afterwards.
- R4: A write with status_we_i and wdata_i[i]=1 clears status_o[i] (i in 0..6) at the next edge.
- R5: A status write leaves alone every bit i in 0..6 that has wdata_i[i]=0. Writing to bit 7 has no effect on status_o[7].
- R6: A write with mask_we_i loads mask_o with wdata_i[6:0]. wdata_i[7] is ignored.
- R7: irq_o is 1 in the cycle after a cycle in which status_o[6:0] & mask_o is nonzero, and 0 in the cycle after a cycle in which it is zero.
- R8: status_o[7] goes to 1 after a pulse on enter_reset_i or on event_i[4]. When the overwrite cause is not active, a pulse on start_cmd_i clears it.
- R9: An overwrite cause is also cleared by frame_taken_i. A stop cause is cleared only by start_cmd_i, so status_o[7] stays 1 after frame_taken_i while the controller is stopped.
- R10: status_o[7] never drives irq_o.
- R11: If the cause that sets status_o[7] and the one that clears it arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| event_i | input | 7 | Event pulses, one per status bit 0..6 |
| enter_reset_i | input | 1 | Pulse: the controller enters the stopped state |
| start_cmd_i | input | 1 | Pulse: a start command was issued |
| frame_taken_i | input | 1 | Pulse: the host removed a frame from the ring |
| status_we_i | input | 1 | Status write strobe (write 1 to clear) |
| mask_we_i | input | 1 | Mask write strobe |
| wdata_i | input | 8 | Write data |
| status_o | output | 8 | Interrupt status word |
| mask_o | output | 7 | Interrupt mask |
| irq_o | output | 1 | Registered interrupt level |

## Verification
The bench builds the unit with its default seven event bits. At that size, every pairing of the 128 mask values with the 128 event patterns can be swept. Each pairing is preceded by a full clear, so each mask and event bit is checked against every combination of the others, both for the latched word and for the delayed interrupt level. Directed cases then cover the corner cases of the stop/overwrite bit and the rule that a set wins over a same-cycle clear.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int unsigned NUM_EVT_DEF = 7;
  localparam int unsigned OVW_IDX_DEF = 4;
endpackage

// File: rtl/isr_event_latch.sv
module isr_event_latch #(
  parameter int unsigned NUM_EVT = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] set_i,
  input  logic               clr_we_i,
  input  logic [NUM_EVT-1:0] clr_bits_i,
  output logic [NUM_EVT-1:0] stat_o
);
  logic [NUM_EVT-1:0] stat_q;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         stat_q[i] <= 1'b0;
      else if (set_i[i])                   stat_q[i] <= 1'b1;
      else if (clr_we_i && clr_bits_i[i])  stat_q[i] <= 1'b0;
    end

    assert_set_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> stat_q[i]);
    assert_w1c_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_we_i && clr_bits_i[i] && !set_i[i]) |=> !stat_q[i]);
    assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i[i] && !(clr_we_i && clr_bits_i[i])) |=> $stable(stat_q[i]));
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/isr_reset_state.sv
module isr_reset_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enter_i,
  input  logic ovw_i,
  input  logic start_i,
  input  logic frame_taken_i,
  output logic rst_bit_o
);
  logic stop_q, ovw_q;

  // stop cause: only a start command releases it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stop_q <= 1'b1;
    else if (enter_i) stop_q <= 1'b1;
    else if (start_i) stop_q <= 1'b0;
  end

  // overwrite cause: released by start or by a frame leaving the ring
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       ovw_q <= 1'b0;
    else if (ovw_i)                    ovw_q <= 1'b1;
    else if (start_i || frame_taken_i) ovw_q <= 1'b0;
  end

  assign rst_bit_o = stop_q | ovw_q;

  assert_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enter_i || ovw_i) |=> rst_bit_o);
  assert_start_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !enter_i && !ovw_i) |=> !rst_bit_o);
  assert_stop_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_q && !start_i) |=> rst_bit_o);
endmodule

// File: rtl/isr_irq_gen.sv
module isr_irq_gen #(
  parameter int unsigned NUM_EVT = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mask_we_i,
  input  logic [NUM_EVT-1:0] mask_wdata_i,
  input  logic [NUM_EVT-1:0] stat_i,
  output logic [NUM_EVT-1:0] mask_o,
  output logic               irq_o
);
  logic [NUM_EVT-1:0] mask_q;
  logic               irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(stat_i & mask_q);
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  assert_mask_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> (mask_o == $past(mask_wdata_i)));
  assert_irq_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_i & mask_o) == '0) |=> !irq_o);
endmodule

// File: rtl/isr_unit.sv
module isr_unit
  import isr_pkg::*;
#(
  parameter int unsigned NUM_EVT = NUM_EVT_DEF,
  parameter int unsigned OVW_IDX = OVW_IDX_DEF,
  localparam int unsigned DATA_W = NUM_EVT + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] event_i,
  input  logic               enter_reset_i,
  input  logic               start_cmd_i,
  input  logic               frame_taken_i,
  input  logic               status_we_i,
  input  logic               mask_we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  status_o,
  output logic [NUM_EVT-1:0] mask_o,
  output logic               irq_o
);
  logic [NUM_EVT-1:0] evt_stat;
  logic               rst_bit;
  logic               unused_wtop;

  assign unused_wtop = wdata_i[DATA_W-1];

  isr_event_latch #(.NUM_EVT(NUM_EVT)) u_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (event_i),
    .clr_we_i   (status_we_i),
    .clr_bits_i (wdata_i[NUM_EVT-1:0]),
    .stat_o     (evt_stat)
  );

  isr_reset_state u_rst_state (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .enter_i       (enter_reset_i),
    .ovw_i         (event_i[OVW_IDX]),
    .start_i       (start_cmd_i),
    .frame_taken_i (frame_taken_i),
    .rst_bit_o     (rst_bit)
  );

  isr_irq_gen #(.NUM_EVT(NUM_EVT)) u_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mask_we_i    (mask_we_i),
    .mask_wdata_i (wdata_i[NUM_EVT-1:0]),
    .stat_i       (evt_stat),
    .mask_o       (mask_o),
    .irq_o        (irq_o)
  );

  assign status_o = {rst_bit, evt_stat};

  assert_irq_raise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o[NUM_EVT-1:0] & mask_o) != '0) |=> irq_o);
  assert_top_no_irq_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[NUM_EVT-1:0] == '0) |=> !irq_o);
  assert_ovw_to_top_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_i[OVW_IDX] |=> (status_o[OVW_IDX] && status_o[DATA_W-1]));
endmodule

// File: tb/test_isr_unit.sv
module test_isr_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] event_i = '0;
  logic       enter_reset_i = 1'b0, start_cmd_i = 1'b0, frame_taken_i = 1'b0;
  logic       status_we_i = 1'b0, mask_we_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] status_o;
  logic [6:0] mask_o;
  logic       irq_o;

  int errors = 0, checks = 0;
  logic [7:0] es;
  logic [6:0] em;
  logic       eirq, estop, eovw;
  logic       done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  isr_unit i_isr_unit (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle, advance the model, compare outputs
  task automatic step(string tag, logic [6:0] ev, logic en, logic st, logic ft,
                      logic ws, logic wm, logic [7:0] wd);
    logic irq_n;
    event_i = ev; enter_reset_i = en; start_cmd_i = st; frame_taken_i = ft;
    status_we_i = ws; mask_we_i = wm; wdata_i = wd;
    @(posedge clk_i);
    irq_n = |(es[6:0] & em);
    for (int i = 0; i < 7; i++)
      if (ev[i]) es[i] = 1'b1;
      else if (ws && wd[i]) es[i] = 1'b0;
    estop = en ? 1'b1 : (st ? 1'b0 : estop);
    eovw  = ev[4] ? 1'b1 : ((st || ft) ? 1'b0 : eovw);
    es[7] = estop | eovw;
    if (wm) em = wd[6:0];
    eirq = irq_n;
    @(negedge clk_i);
    event_i = '0; enter_reset_i = 0; start_cmd_i = 0; frame_taken_i = 0;
    status_we_i = 0; mask_we_i = 0; wdata_i = '0;
    chk(tag, status_o, es);
    chk("R6 mask", {1'b0, mask_o}, {1'b0, em});
    chk("R7 irq", {7'b0, irq_o}, {7'b0, eirq});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    es = 8'h80; em = '0; eirq = 0; estop = 1; eovw = 0;
    repeat (2) @(negedge clk_i);
    chk("R1 status", status_o, 8'h80);
    chk("R1 mask", {1'b0, mask_o}, 8'h00);
    chk("R1 irq", {7'b0, irq_o}, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R8: start releases stop cause
    step("R8 start", 7'h00, 0, 1, 0, 0, 0, 8'h00);
    chk("R8 top bit clear", {7'b0, status_o[7]}, 8'h00);

    // R2/R4/R7 sweep of all masks against all event patterns
    for (int m = 0; m < 128; m++) begin
      step("R6 mask write", 7'h00, 0, 0, 0, 0, 1, {1'b1, m[6:0]});
      for (int s = 0; s < 128; s++) begin
        step("R4 clear", 7'h00, 0, 0, 1, 1, 0, 8'hFF);
        step("R2 event", s[6:0], 0, 0, 0, 0, 0, 8'h00);
        step("R7 level", 7'h00, 0, 0, 0, 0, 0, 8'h00);
      end
    end

    // R3: set beats same-cycle clear
    step("R4 clear", 7'h00, 0, 0, 1, 1, 0, 8'hFF);
    step("R3 set vs clear", 7'h04, 0, 0, 0, 1, 0, 8'h7F);
    chk("R3 bit2", {7'b0, status_o[2]}, 8'h01);

    // R5: zero bits and bit 7 untouched by a write
    step("R2 event", 7'h21, 0, 0, 0, 0, 0, 8'h00);
    step("R5 partial", 7'h00, 0, 0, 0, 1, 0, 8'h81);
    chk("R5 bit5 kept", {7'b0, status_o[5]}, 8'h01);

    // R10: only bit 7 set, full mask, no interrupt
    step("R4 clear", 7'h00, 0, 0, 0, 1, 1, 8'hFF);
    step("R8 enter", 7'h00, 1, 0, 0, 0, 0, 8'h00);
    step("R10 idle", 7'h00, 0, 0, 0, 0, 0, 8'h00);
    chk("R10 no irq", {7'b0, irq_o}, 8'h00);

    // R9: frame taken does not release stop cause
    step("R9 frame taken", 7'h00, 0, 0, 1, 0, 0, 8'h00);
    chk("R9 top kept", {7'b0, status_o[7]}, 8'h01);
    // R11: enter and start together keeps the bit
    step("R11 set vs clear", 7'h00, 1, 1, 0, 0, 0, 8'h00);
    chk("R11 top kept", {7'b0, status_o[7]}, 8'h01);
    step("R8 start", 7'h00, 0, 1, 0, 0, 0, 8'h00);
    // R9: overwrite cause released by frame taken
    step("R9 ovw", 7'h10, 0, 0, 0, 0, 0, 8'h00);
    chk("R9 ovw top set", {7'b0, status_o[7]}, 8'h01);
    step("R9 frame taken", 7'h00, 0, 0, 1, 0, 0, 8'h00);
    chk("R9 ovw released", {7'b0, status_o[7]}, 8'h00);
    // R11: overwrite and frame taken together
    step("R11 ovw vs taken", 7'h10, 0, 0, 1, 0, 0, 8'h00);
    chk("R11 ovw kept", {7'b0, status_o[7]}, 8'h01);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule